// File: doc/BRIEF.md
# Write-Combining Store Buffer

This block sits on the uncached write path of a processor. It takes word-sized store requests and holds them in a 32-byte staging area instead of forwarding each one to memory. Every byte of that area has its own valid flag. Stores that land in the same 32-byte aligned region are merged there, and a later store to a byte that is already held replaces that byte. Nothing written here is ever kept as a cached copy. Once the region has been handed to memory, the buffer forgets it.

The gathered region goes to memory as one burst of fixed length. Every beat carries a byte mask that marks only the bytes that were written. Three events start a burst. The first is a buffer in which every byte is valid. The second is a store to a different region. The third is an explicit flush request. While a burst is in flight the processor side is stalled. When the memory side accepts the final beat, the buffer is empty and ready to open a new region.

Top module: `wc_store_buffer`

## Requirements
- R1: After reset the buffer holds no valid bytes, `wr_ready` is 1 and `mem_valid` is 0.
- R2: Stores to the open region cause no memory traffic by themselves. A store to a byte that is already valid replaces its data, and only the newest value reaches memory.
- R3: A burst has 4 beats of 8 bytes each. Beat k has address region_base + 8*k and carries buffer bytes 8k to 8k+7, with byte 8k in `mem_data[7:0]`. `mem_last` is 1 on beat 3 only. region_base is the region number times 32.
- R4: Bit j of `mem_mask` on beat k is 1 exactly when buffer byte 8k+j is valid.
- R5: When all 32 bytes are valid, a burst starts with no other trigger.
- R6: A store to a region other than the open one is held off (`wr_ready` 0) until the current contents have drained. It is then accepted into an empty buffer and opens its own region.
- R7: `flush_req` with a non-empty buffer drains it. With an empty buffer it produces no beat and leaves `wr_ready` at 1.
- R8: `wr_ready` is 0 for the whole burst. A beat that is not accepted (`mem_ready` 0) stays on the bus unchanged.
- R9: Once the last beat is accepted, no byte remains valid, so the next burst carries only bytes stored after it.
- R10: Store lane i (data bits 8i+7:8i, byte enable bit i) goes to buffer byte 4*word_index + i, where word_index is `wr_waddr[2:0]` and the region is `wr_waddr[29:3]`. Lanes whose enable is 0 are left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Store request present |
| wr_ready | output | 1 | Store accepted this cycle when high together with `wr_valid` |
| wr_waddr | input | 30 | Word address of the store |
| wr_data | input | 32 | Store data, lane i in bits 8i+7:8i |
| wr_be | input | 4 | Per-lane byte enables |
| flush_req | input | 1 | Request to push buffered bytes to memory |
| mem_valid | output | 1 | Burst beat present |
| mem_ready | input | 1 | Memory accepts the current beat |
| mem_addr | output | 32 | Byte address of the current beat |
| mem_data | output | 64 | Beat data |
| mem_mask | output | 8 | Valid-byte mask of the beat |
| mem_last | output | 1 | Final beat of the burst |

## Verification
The bench targets several corner cases. The first is a store to a foreign region that arrives while the buffer holds data. A design that merged it would corrupt the old region's burst, and one that dropped it would lose the store. It also checks the last store that completes all 32 bytes; a missed full trigger would leave those bytes stranded until a flush. Memory back-pressure is applied at random. A beat counter that advanced without `mem_ready` would show up as a skipped address. Repeated stores to the same byte, and a flush of an empty buffer, are also covered. Getting the first wrong sends a stale value. Getting the second wrong emits a spurious burst that is all mask-zero.

// File: rtl/wcb_pkg.sv
package wcb_pkg;

  typedef enum logic {
    WCB_GATHER = 1'b0,
    WCB_DRAIN  = 1'b1
  } wcb_state_t;

  // position of a byte inside the buffer from its group index and offset
  function automatic int byte_slot(input int group, input int offs, input int group_bytes);
    return group * group_bytes + offs;
  endfunction

  // byte offset of a beat from the region base
  function automatic int beat_offset(input int beat, input int beat_bytes);
    return beat * beat_bytes;
  endfunction

endpackage

// File: rtl/wcb_byte_store.sv
module wcb_byte_store #(
  parameter int BUF_BYTES  = 32,
  parameter int WORD_BYTES = 4,
  localparam int WORDS  = BUF_BYTES / WORD_BYTES,
  localparam int WIDX_W = $clog2(WORDS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [WIDX_W-1:0]      word_idx,
  input  logic [WORD_BYTES*8-1:0] wr_data,
  input  logic [WORD_BYTES-1:0]  wr_be,
  input  logic                   clr,
  output logic [BUF_BYTES*8-1:0] buf_data,
  output logic [BUF_BYTES-1:0]   buf_valid
);

  for (genvar g = 0; g < BUF_BYTES; g++) begin : g_byte
    localparam int GW = g / WORD_BYTES;
    localparam int GL = g % WORD_BYTES;
    logic hit;
    assign hit = wr_en && (int'(word_idx) == GW) && wr_be[GL] &&
                 (wcb_pkg::byte_slot(GW, GL, WORD_BYTES) == g);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        buf_valid[g]       <= 1'b0;
        buf_data[8*g +: 8] <= 8'h00;
      end else if (clr) begin
        buf_valid[g]       <= 1'b0;
      end else if (hit) begin
        buf_valid[g]       <= 1'b1;
        buf_data[8*g +: 8] <= wr_data[8*GL +: 8];
      end
    end
  end

  // R10
  untouched_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !clr) |=> $stable(buf_valid));

  // R9
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (buf_valid == '0));

endmodule

// File: rtl/wcb_ctrl.sv
module wcb_ctrl #(
  parameter int WADDR_W   = 30,
  parameter int WIDX_W    = 3,
  parameter int BUF_BYTES = 32,
  parameter int NBEAT     = 4,
  localparam int REG_W  = WADDR_W - WIDX_W,
  localparam int BIDX_W = $clog2(NBEAT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  input  logic [WADDR_W-1:0]   wr_waddr,
  input  logic                 flush_req,
  input  logic                 mem_ready,
  input  logic [BUF_BYTES-1:0] buf_valid,
  output logic                 wr_ready,
  output logic                 accept,
  output logic [WIDX_W-1:0]    word_idx,
  output logic                 clr,
  output logic                 drain_active,
  output logic [BIDX_W-1:0]    beat_idx,
  output logic                 beat_last,
  output logic [REG_W-1:0]     base_region
);
  import wcb_pkg::*;

  wcb_state_t         state_q;
  logic [BIDX_W-1:0]  beat_q;
  logic [REG_W-1:0]   base_q;

  // named events
  logic buf_empty, buf_full, region_hit, miss_evt, flush_evt, start_drain, beat_fire;

  assign buf_empty   = ~|buf_valid;
  assign buf_full    = &buf_valid;
  assign region_hit  = (wr_waddr[WADDR_W-1:WIDX_W] == base_q);
  assign miss_evt    = wr_valid && !buf_empty && !region_hit;
  assign flush_evt   = flush_req && !buf_empty;
  assign start_drain = (state_q == WCB_GATHER) && (buf_full || flush_evt || miss_evt);

  assign drain_active = (state_q == WCB_DRAIN);
  assign wr_ready     = (state_q == WCB_GATHER) && !start_drain;
  assign accept       = wr_valid && wr_ready;
  assign word_idx     = wr_waddr[WIDX_W-1:0];
  assign beat_last    = (beat_q == BIDX_W'(NBEAT - 1));
  assign beat_fire    = drain_active && mem_ready;
  assign clr          = beat_fire && beat_last;
  assign beat_idx     = beat_q;
  assign base_region  = base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WCB_GATHER;
      beat_q  <= '0;
      base_q  <= '0;
    end else begin
      if (accept && buf_empty) base_q <= wr_waddr[WADDR_W-1:WIDX_W];
      case (state_q)
        WCB_GATHER: begin
          if (start_drain) begin
            state_q <= WCB_DRAIN;
            beat_q  <= '0;
          end
        end
        WCB_DRAIN: begin
          if (beat_fire) begin
            beat_q <= beat_q + BIDX_W'(1);
            if (beat_last) state_q <= WCB_GATHER;
          end
        end
        default: state_q <= WCB_GATHER;
      endcase
    end
  end

  // R8
  stall_in_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_active |-> !wr_ready);

  // R8
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_active && !mem_ready) |=> (drain_active && $stable(beat_q)));

  // R6
  same_region_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !buf_empty) |-> region_hit);

  // R5
  full_starts_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!drain_active && buf_full) |=> drain_active);

  // R7
  empty_flush_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!drain_active && buf_empty) |=> !drain_active);

endmodule

// File: rtl/wcb_beat_sel.sv
module wcb_beat_sel #(
  parameter int ADDR_W     = 32,
  parameter int BUF_BYTES  = 32,
  parameter int BEAT_BYTES = 8,
  localparam int NBEAT  = BUF_BYTES / BEAT_BYTES,
  localparam int BIDX_W = $clog2(NBEAT),
  localparam int OFF_W  = $clog2(BUF_BYTES),
  localparam int REG_W  = ADDR_W - OFF_W
) (
  input  logic [BUF_BYTES*8-1:0]  buf_data,
  input  logic [BUF_BYTES-1:0]    buf_valid,
  input  logic [BIDX_W-1:0]       beat_idx,
  input  logic [REG_W-1:0]        base_region,
  output logic [ADDR_W-1:0]       beat_addr,
  output logic [BEAT_BYTES*8-1:0] beat_data,
  output logic [BEAT_BYTES-1:0]   beat_mask
);

  always_comb begin
    beat_addr = {base_region, {OFF_W{1'b0}}} +
                ADDR_W'(wcb_pkg::beat_offset(int'(beat_idx), BEAT_BYTES));
    for (int j = 0; j < BEAT_BYTES; j++) begin
      beat_data[8*j +: 8] = buf_data[8*wcb_pkg::byte_slot(int'(beat_idx), j, BEAT_BYTES) +: 8];
      beat_mask[j]        = buf_valid[wcb_pkg::byte_slot(int'(beat_idx), j, BEAT_BYTES)];
    end
  end

endmodule

// File: rtl/wc_store_buffer.sv
module wc_store_buffer #(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  parameter int BUF_BYTES  = 32,
  parameter int BEAT_BYTES = 8,
  localparam int LANE_W  = $clog2(WORD_BYTES),
  localparam int WADDR_W = ADDR_W - LANE_W,
  localparam int WORDS   = BUF_BYTES / WORD_BYTES,
  localparam int WIDX_W  = $clog2(WORDS),
  localparam int NBEAT   = BUF_BYTES / BEAT_BYTES,
  localparam int BIDX_W  = $clog2(NBEAT),
  localparam int OFF_W   = $clog2(BUF_BYTES),
  localparam int REG_W   = ADDR_W - OFF_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  input  logic [WADDR_W-1:0]      wr_waddr,
  input  logic [WORD_BYTES*8-1:0] wr_data,
  input  logic [WORD_BYTES-1:0]   wr_be,
  input  logic                    flush_req,
  output logic                    mem_valid,
  input  logic                    mem_ready,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [BEAT_BYTES*8-1:0] mem_data,
  output logic [BEAT_BYTES-1:0]   mem_mask,
  output logic                    mem_last
);

  logic                   accept, clr, drain_active, beat_last;
  logic [WIDX_W-1:0]      word_idx;
  logic [BIDX_W-1:0]      beat_idx;
  logic [REG_W-1:0]       base_region;
  logic [BUF_BYTES*8-1:0] buf_data;
  logic [BUF_BYTES-1:0]   buf_valid;

  wcb_ctrl #(
    .WADDR_W(WADDR_W), .WIDX_W(WIDX_W), .BUF_BYTES(BUF_BYTES), .NBEAT(NBEAT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_waddr(wr_waddr),
    .flush_req(flush_req), .mem_ready(mem_ready), .buf_valid(buf_valid),
    .wr_ready(wr_ready), .accept(accept), .word_idx(word_idx), .clr(clr),
    .drain_active(drain_active), .beat_idx(beat_idx), .beat_last(beat_last),
    .base_region(base_region)
  );

  wcb_byte_store #(
    .BUF_BYTES(BUF_BYTES), .WORD_BYTES(WORD_BYTES)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(accept), .word_idx(word_idx),
    .wr_data(wr_data), .wr_be(wr_be), .clr(clr),
    .buf_data(buf_data), .buf_valid(buf_valid)
  );

  wcb_beat_sel #(
    .ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES), .BEAT_BYTES(BEAT_BYTES)
  ) u_sel (
    .buf_data(buf_data), .buf_valid(buf_valid), .beat_idx(beat_idx),
    .base_region(base_region), .beat_addr(mem_addr), .beat_data(mem_data),
    .beat_mask(mem_mask)
  );

  assign mem_valid = drain_active;
  assign mem_last  = drain_active && beat_last;

  // R8
  bus_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_mask)));

  // R9
  done_then_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && mem_last) |=> (!mem_valid && wr_ready));

endmodule

// File: tb/wc_store_buffer_tb.sv
module wc_store_buffer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [29:0] wr_waddr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic        flush_req = 1'b0;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr;
  logic [63:0] mem_data;
  logic [7:0]  mem_mask;
  logic        mem_last;

  int n_chk = 0;
  int n_bad = 0;
  int bursts = 0;
  int rx_beat = 0;
  int ready_pct = 100;

  logic [7:0]  m_data [32];
  logic        m_valid [32];
  logic [26:0] m_base = '0;

  wc_store_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_waddr(wr_waddr), .wr_data(wr_data), .wr_be(wr_be), .flush_req(flush_req),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_mask(mem_mask), .mem_last(mem_last)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit model_empty();
    for (int i = 0; i < 32; i++) if (m_valid[i]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [31:0] exp_beat_addr(input int k);
    return {m_base, 5'b0} + 32'(k * 8);
  endfunction

  function automatic logic [7:0] exp_mask(input int k);
    logic [7:0] m;
    for (int j = 0; j < 8; j++) m[j] = m_valid[k*8 + j];
    return m;
  endfunction

  // memory side: drive ready, then record each beat that will be taken
  initial begin
    forever begin
      @(negedge clk);
      mem_ready = ($urandom_range(99) < ready_pct);
      #1;
      if (rst_n && mem_valid) begin
        check(!wr_ready, "R8 wr_ready during burst", 64'(wr_ready), 64'd0);
        if (mem_ready) begin
          logic [63:0] dmask;
          for (int j = 0; j < 8; j++) dmask[8*j +: 8] = m_valid[rx_beat*8 + j] ? 8'hFF : 8'h00;
          check(mem_addr == exp_beat_addr(rx_beat), "R3 beat address", 64'(mem_addr), 64'(exp_beat_addr(rx_beat)));
          check(mem_mask == exp_mask(rx_beat), "R4 beat mask", 64'(mem_mask), 64'(exp_mask(rx_beat)));
          begin
            logic [63:0] ed;
            for (int j = 0; j < 8; j++) ed[8*j +: 8] = m_data[rx_beat*8 + j];
            check((mem_data & dmask) == (ed & dmask), "R2/R3 beat data", mem_data & dmask, ed & dmask);
          end
          check(mem_last == (rx_beat == 3), "R3 last flag", 64'(mem_last), 64'(rx_beat == 3));
          if (rx_beat == 3) begin
            rx_beat = 0;
            bursts++;
            for (int i = 0; i < 32; i++) m_valid[i] = 1'b0;
          end else begin
            rx_beat++;
          end
        end
      end
    end
  end

  task automatic do_write(input logic [29:0] wa, input logic [31:0] d, input logic [3:0] be);
    int waits = 0;
    @(negedge clk);
    #2;
    wr_valid = 1'b1; wr_waddr = wa; wr_data = d; wr_be = be;
    #1;
    while (!wr_ready && waits < 200) begin
      @(negedge clk);
      #3;
      waits++;
    end
    if (!wr_ready) begin
      check(1'b0, "R6 store never accepted", 64'd0, 64'd1);
    end else begin
      if (model_empty()) m_base = wa[29:3];
      for (int i = 0; i < 4; i++)
        if (be[i]) begin
          m_data[wa[2:0]*4 + i]  = d[8*i +: 8];
          m_valid[wa[2:0]*4 + i] = 1'b1;
        end
    end
    @(posedge clk);
    #1;
    wr_valid = 1'b0;
  endtask

  task automatic do_flush();
    int b0 = bursts;
    int waits = 0;
    @(negedge clk);
    #2;
    flush_req = 1'b1;
    if (model_empty()) begin
      repeat (3) @(negedge clk);
      #2;
      check(wr_ready == 1'b1, "R7 empty flush keeps ready", 64'(wr_ready), 64'd1);
      check(bursts == b0, "R7 empty flush sends nothing", 64'(bursts), 64'(b0));
      flush_req = 1'b0;
    end else begin
      while (bursts == b0 && waits < 400) begin
        @(negedge clk);
        #2;
        waits++;
      end
      check(bursts == b0 + 1, "R7 flush drains buffer", 64'(bursts), 64'(b0 + 1));
      flush_req = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int b0;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 32; i++) begin m_valid[i] = 1'b0; m_data[i] = 8'h00; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1
    check(wr_ready == 1'b1, "R1 reset ready", 64'(wr_ready), 64'd1);
    check(mem_valid == 1'b0, "R1 reset no burst", 64'(mem_valid), 64'd0);
    do_flush(); // R7 on an empty buffer after reset

    // R2 merge and overwrite, R10 partial lanes
    b0 = bursts;
    do_write(30'h0000_0400, 32'h1111_1111, 4'hF);
    do_write(30'h0000_0401, 32'hA5A5_A5A5, 4'b0101);
    do_write(30'h0000_0400, 32'h2222_2222, 4'b0011);
    do_write(30'h0000_0407, 32'hDEAD_BEEF, 4'b1000);
    repeat (5) @(negedge clk);
    check(bursts == b0, "R2 no traffic before trigger", 64'(bursts), 64'(b0));
    do_flush();
    do_flush(); // R9: emptied, second flush sends nothing

    // R5 full buffer triggers by itself
    b0 = bursts;
    for (int w = 0; w < 8; w++) do_write(30'h0000_0808 + 30'(w), 32'hC0DE_0000 + 32'(w), 4'hF);
    for (int t = 0; t < 20 && bursts == b0; t++) @(negedge clk);
    check(bursts == b0 + 1, "R5 full trigger", 64'(bursts), 64'(b0 + 1));

    // R6 region change
    b0 = bursts;
    do_write(30'h0000_1003, 32'h0BAD_F00D, 4'b0110);
    do_write(30'h0000_2005, 32'h7777_8888, 4'hF);
    check(bursts == b0 + 1, "R6 old region drained first", 64'(bursts), 64'(b0 + 1));
    check(m_base == 27'h400, "R6 new region opened", 64'(m_base), 64'h400);
    do_flush();

    // R8 random back-pressure with random traffic
    ready_pct = 60;
    for (int n = 0; n < 400; n++) begin
      logic [29:0] wa;
      int r = $urandom_range(2);
      wa = (r == 0) ? 30'h0000_0400 : (r == 1) ? 30'h0000_0408 : 30'h0000_0800;
      wa = wa + 30'($urandom_range(7));
      do_write(wa, $urandom, 4'($urandom_range(15, 1)));
      if ($urandom_range(15) == 0) do_flush();
    end
    do_flush();
    check(bursts > 10, "R3 bursts observed", 64'(bursts), 64'd11);
    ready_pct = 100;
    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule